// File: doc/BRIEF.md
# Parallel Header-Field Action Stage

This block is one action stage of a match-action packet pipeline. A packet arrives as a header vector of fixed-width field slots, together with the outcome of an upstream table lookup. That outcome is an action number and one word of action data. The stage uses the action number to read a wide instruction word from a small programmable instruction store. The word holds one micro-operation for every field slot. Each slot has its own ALU, and all slots compute in the same cycle. The rewritten header vector and a deny flag leave the stage one cycle later.

Each slot computes `result = A op B`. A is any slot of the incoming vector. B is any slot of the incoming vector, the action data, or a small immediate held in the micro-operation. All operands come from the vector as it entered the stage, so the edits of one action behave as a parallel assignment. Typical actions are decrementing a hop count, loading a new destination address from action data, and marking a packet as denied. Stages of this kind are chained, and each stage sees the output of the one before it. A configuration port loads the instruction store. Valid/ready handshakes sit on both sides of the stage.

Top module: `hdrActionStage`

## Requirements
- R1: During reset and in the first cycle after it, `outValid` is 0. `inReady` is 1 whenever `outValid` is 0.
- R2: A write with `cfgWe`=1 stores `cfgData` at entry `cfgAddr` of the instruction store, which has 16 entries. An accepted packet executes the entry named by `actionIdx`.
- R3: The instruction word is 161 bits wide. The micro-operation for slot i occupies bits [20*i+19 : 20*i]. Within a micro-operation, bits [3:0] are the opcode, [6:4] select the A slot, [9:7] select the B slot, [11:10] choose the B source and [19:12] are an 8-bit immediate.
- R4: The opcodes are 1 = A, 2 = A+B, 3 = A-B, 4 = A&B, 5 = A|B, 6 = A^B, 7 = B and 8 = A-1. All results are taken modulo 2^32.
- R5: The B source code selects the field chosen by the B select when 0, the action data when 1, and the zero-extended immediate when 2. Code 3 gives zero.
- R6: Opcode 0 and the opcodes 9 to 15 leave the slot's own incoming value unchanged.
- R7: Every operand is read from the incoming vector. For example, two slots that each copy the other exchange their values.
- R8: Bit 160 of the instruction word appears on `dropOut` together with the packet's output vector.
- R9: A packet accepted at a clock edge (`inValid` and `inReady` both 1) is presented with `outValid`=1 right after that edge. If `outReady` is 1 and no new packet is accepted, `outValid` falls at the next edge.
- R10: While `outValid`=1 and `outReady`=0, `inReady` is 0, and `hdrOut` and `dropOut` hold their values. When `outReady` returns, a waiting packet is accepted at the same edge at which the held one leaves.
- R11: A packet accepted at the same edge as a configuration write to its entry executes the old content of that entry. A packet accepted afterwards executes the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Incoming packet is present |
| inReady | output | 1 | Stage can accept a packet |
| actionIdx | input | 4 | Action number from the lookup |
| actionData | input | 32 | Action data word from the lookup |
| hdrIn | input | 256 | Incoming header vector; slot i is bits [32*i+31 : 32*i] |
| outValid | output | 1 | Output packet is present |
| outReady | input | 1 | Downstream accepts the output packet |
| hdrOut | output | 256 | Rewritten header vector |
| dropOut | output | 1 | Deny flag of the output packet |
| cfgWe | input | 1 | Instruction store write enable |
| cfgAddr | input | 4 | Instruction store entry to write |
| cfgData | input | 161 | Instruction word to write |

## Verification
There are two places where functions collide in one cycle. The first is a configuration write to an entry at the same edge as a packet that looks up that entry. The bench drives both in one cycle and expects the old word's result. It then sends a second packet and expects the new word's result. The second is the release of a held output at the same edge as the acceptance of a waiting input. The bench first stalls the output and checks that the held vector stays frozen and that `inReady` stays low. It then raises `outReady` with the next packet waiting, and expects that packet's result right after the single edge. An arithmetic sweep over every opcode, every B source and boundary-valued headers covers the ALUs.

// File: rtl/hdrStagePkg.sv
package hdrStagePkg;

  localparam int OPC_W   = 4;
  localparam int BMODE_W = 2;
  localparam int IMM_W   = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'd0,
    OP_COPY = 4'd1,
    OP_ADD  = 4'd2,
    OP_SUB  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_SETB = 4'd7,
    OP_DEC  = 4'd8
  } opKind_t;

  typedef enum logic [BMODE_W-1:0] {
    B_FIELD = 2'd0,
    B_ADATA = 2'd1,
    B_IMM   = 2'd2,
    B_ZERO  = 2'd3
  } bSrc_t;

  typedef struct packed {
    logic loadOut;
  } stageStrobes_t;

endpackage

// File: rtl/hdrInstrMem.sv
module hdrInstrMem #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 161,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  // Asynchronous read: a write at this edge is seen only by later lookups.
  assign rdData = mem[rdAddr];

endmodule

// File: rtl/hdrFieldAlu.sv
module hdrFieldAlu import hdrStagePkg::*; #(
  parameter int FIELD_W = 32
) (
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FIELD_W-1:0] opA,
  input  logic [FIELD_W-1:0] opB,
  input  logic [FIELD_W-1:0] ownVal,
  output logic [FIELD_W-1:0] result
);

  always_comb begin
    case (opKind_t'(opcode))
      OP_COPY: result = opA;
      OP_ADD:  result = opA + opB;
      OP_SUB:  result = opA - opB;
      OP_AND:  result = opA & opB;
      OP_OR:   result = opA | opB;
      OP_XOR:  result = opA ^ opB;
      OP_SETB: result = opB;
      OP_DEC:  result = opA - FIELD_W'(1);
      default: result = ownVal;
    endcase
  end

endmodule

// File: rtl/hdrStageDatapath.sv
module hdrStageDatapath import hdrStagePkg::*; #(
  parameter int NUM_SLOTS  = 8,
  parameter int FIELD_W    = 32,
  parameter int IMEM_DEPTH = 16,
  localparam int SEL_W   = $clog2(NUM_SLOTS),
  localparam int UOP_W   = OPC_W + 2*SEL_W + BMODE_W + IMM_W,
  localparam int INSTR_W = NUM_SLOTS*UOP_W + 1,
  localparam int HDR_W   = NUM_SLOTS*FIELD_W,
  localparam int IDX_W   = $clog2(IMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  stageStrobes_t      strobes,
  input  logic [HDR_W-1:0]   hdrIn,
  input  logic [IDX_W-1:0]   actionIdx,
  input  logic [FIELD_W-1:0] actionData,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgAddr,
  input  logic [INSTR_W-1:0] cfgData,
  output logic [HDR_W-1:0]   hdrOut,
  output logic               dropOut
);

  localparam int A_LSB   = OPC_W;
  localparam int B_LSB   = OPC_W + SEL_W;
  localparam int M_LSB   = OPC_W + 2*SEL_W;
  localparam int I_LSB   = M_LSB + BMODE_W;
  localparam int DROP_BIT = INSTR_W - 1;

  logic [INSTR_W-1:0] curInstr;
  logic [FIELD_W-1:0] slotIn [NUM_SLOTS];
  logic [HDR_W-1:0]   nextHdr;

  hdrInstrMem #(.DEPTH(IMEM_DEPTH), .WORD_W(INSTR_W)) uMem (
    .clk    (clk),
    .wrEn   (cfgWe),
    .wrAddr (cfgAddr),
    .wrData (cfgData),
    .rdAddr (actionIdx),
    .rdData (curInstr)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlotIn
    assign slotIn[g] = hdrIn[g*FIELD_W +: FIELD_W];
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gLane
    logic [UOP_W-1:0]   uop;
    logic [OPC_W-1:0]   opc;
    logic [SEL_W-1:0]   aSel;
    logic [SEL_W-1:0]   bSel;
    logic [BMODE_W-1:0] bMode;
    logic [IMM_W-1:0]   imm;
    logic [FIELD_W-1:0] opA;
    logic [FIELD_W-1:0] opB;
    logic [FIELD_W-1:0] laneRes;

    assign uop   = curInstr[g*UOP_W +: UOP_W];
    assign opc   = uop[OPC_W-1:0];
    assign aSel  = uop[A_LSB +: SEL_W];
    assign bSel  = uop[B_LSB +: SEL_W];
    assign bMode = uop[M_LSB +: BMODE_W];
    assign imm   = uop[I_LSB +: IMM_W];

    // Every operand comes from the incoming vector: parallel-assignment semantics.
    assign opA = slotIn[aSel];

    always_comb begin
      case (bSrc_t'(bMode))
        B_FIELD: opB = slotIn[bSel];
        B_ADATA: opB = actionData;
        B_IMM:   opB = {{(FIELD_W-IMM_W){1'b0}}, imm};
        default: opB = '0;
      endcase
    end

    hdrFieldAlu #(.FIELD_W(FIELD_W)) uAlu (
      .opcode (opc),
      .opA    (opA),
      .opB    (opB),
      .ownVal (slotIn[g]),
      .result (laneRes)
    );

    assign nextHdr[g*FIELD_W +: FIELD_W] = laneRes;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdrOut  <= '0;
      dropOut <= 1'b0;
    end else if (strobes.loadOut) begin
      hdrOut  <= nextHdr;
      dropOut <= curInstr[DROP_BIT];
    end
  end

endmodule

// File: rtl/hdrStageControl.sv
module hdrStageControl import hdrStagePkg::*; (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output stageStrobes_t strobes
);

  logic acceptIn;

  assign inReady         = !outValid || outReady;
  assign acceptIn        = inValid && inReady;
  assign strobes.loadOut = acceptIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
    end else if (acceptIn) begin
      outValid <= 1'b1;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/hdrActionStage.sv
module hdrActionStage import hdrStagePkg::*; #(
  parameter int NUM_SLOTS  = 8,
  parameter int FIELD_W    = 32,
  parameter int IMEM_DEPTH = 16,
  localparam int SEL_W   = $clog2(NUM_SLOTS),
  localparam int UOP_W   = OPC_W + 2*SEL_W + BMODE_W + IMM_W,
  localparam int INSTR_W = NUM_SLOTS*UOP_W + 1,
  localparam int HDR_W   = NUM_SLOTS*FIELD_W,
  localparam int IDX_W   = $clog2(IMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic [IDX_W-1:0]   actionIdx,
  input  logic [FIELD_W-1:0] actionData,
  input  logic [HDR_W-1:0]   hdrIn,
  output logic               outValid,
  input  logic               outReady,
  output logic [HDR_W-1:0]   hdrOut,
  output logic               dropOut,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgAddr,
  input  logic [INSTR_W-1:0] cfgData
);

  stageStrobes_t strobes;

  hdrStageControl uCtl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  hdrStageDatapath #(
    .NUM_SLOTS  (NUM_SLOTS),
    .FIELD_W    (FIELD_W),
    .IMEM_DEPTH (IMEM_DEPTH)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .hdrIn      (hdrIn),
    .actionIdx  (actionIdx),
    .actionData (actionData),
    .cfgWe      (cfgWe),
    .cfgAddr    (cfgAddr),
    .cfgData    (cfgData),
    .hdrOut     (hdrOut),
    .dropOut    (dropOut)
  );

endmodule

// File: rtl/hdrActionStageChecker.sv
module hdrActionStageChecker #(
  parameter int HDR_W = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [HDR_W-1:0] hdrOut,
  input logic             dropOut
);

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !outValid);

  assert_ready_when_empty_R1: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> inReady);

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> outValid);

  assert_drain_R9: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && !inValid |=> !outValid);

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |-> !inReady);

  assert_hold_output_R10: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(hdrOut) && $stable(dropOut));

endmodule

bind hdrActionStage hdrActionStageChecker #(.HDR_W(HDR_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .hdrOut   (hdrOut),
  .dropOut  (dropOut)
);

// File: tb/sim_hdrActionStage.sv
module sim_hdrActionStage;

  localparam int NS      = 8;
  localparam int FW      = 32;
  localparam int UW      = 20;
  localparam int IW      = NS*UW + 1;
  localparam int HW      = NS*FW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [3:0]    actionIdx = '0;
  logic [FW-1:0] actionData = '0;
  logic [HW-1:0] hdrIn = '0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic [HW-1:0] hdrOut;
  logic          dropOut;
  logic          cfgWe = 1'b0;
  logic [3:0]    cfgAddr = '0;
  logic [IW-1:0] cfgData = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hdrActionStage u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .actionIdx(actionIdx), .actionData(actionData), .hdrIn(hdrIn),
    .outValid(outValid), .outReady(outReady), .hdrOut(hdrOut), .dropOut(dropOut),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData)
  );

  function automatic logic [UW-1:0] mkUop(int op, int a, int b, int bm, int imm);
    logic [UW-1:0] u;
    u = '0;
    u[3:0]   = op[3:0];
    u[6:4]   = a[2:0];
    u[9:7]   = b[2:0];
    u[11:10] = bm[1:0];
    u[19:12] = imm[7:0];
    return u;
  endfunction

  function automatic logic [FW-1:0] expLane(int op, logic [FW-1:0] a,
                                             logic [FW-1:0] b, logic [FW-1:0] own);
    case (op)
      1: return a;
      2: return a + b;
      3: return a - b;
      4: return a & b;
      5: return a | b;
      6: return a ^ b;
      7: return b;
      8: return a - 32'd1;
      default: return own;
    endcase
  endfunction

  task automatic check(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeInstr(logic [3:0] addr, logic [IW-1:0] word);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = addr; cfgData = word;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Drives one packet at a negedge; returns at the negedge after its acceptance edge.
  task automatic sendPkt(logic [3:0] idx, logic [FW-1:0] ad, logic [HW-1:0] hv);
    @(negedge clk);
    inValid = 1'b1; actionIdx = idx; actionData = ad; hdrIn = hv;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  logic [FW-1:0] expHdr [NS];

  initial begin
    logic [HW-1:0] hv;
    logic [IW-1:0] word;
    logic [IW-1:0] wordB;
    logic [FW-1:0] ad;
    logic [HW-1:0] held;

    // R1: reset state
    @(negedge clk);
    @(negedge clk);
    check("R1 outValid in reset", {31'd0, outValid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outValid after reset", {31'd0, outValid}, 32'd0);
    check("R1 inReady after reset", {31'd0, inReady}, 32'd1);

    // Arithmetic sweep: R3 layout, R4 opcodes, R5 B sources, R6 no-op codes, R8 drop bit
    for (int op = 0; op < 16; op++) begin
      for (int bm = 0; bm < 4; bm++) begin
        for (int pat = 0; pat < 3; pat++) begin
          logic [FW-1:0] sv [NS];
          for (int i = 0; i < NS; i++) begin
            if (pat == 0)      sv[i] = FW'(i);
            else if (pat == 1) sv[i] = 32'hFFFF_FFF0 + FW'(i);
            else               sv[i] = FW'(i + 1) * 32'h9E37_79B9;
            hv[i*FW +: FW] = sv[i];
          end
          ad = 32'h1234_5678 ^ FW'(pat * 32'h0F0F_0F0F);
          word = '0;
          for (int i = 0; i < NS; i++) begin
            int sa;
            int sb;
            int im;
            logic [FW-1:0] bv;
            sa = (i + op + pat) % NS;
            sb = (3*i + bm + 1) % NS;
            im = (op*16 + bm*5 + i*7) % 256;
            word[i*UW +: UW] = mkUop(op, sa, sb, bm, im);
            case (bm)
              0: bv = sv[sb];
              1: bv = ad;
              2: bv = FW'(im);
              default: bv = '0;
            endcase
            expHdr[i] = expLane(op, sv[sa], bv, sv[i]);
          end
          word[IW-1] = op[0] ^ pat[0];
          writeInstr(4'((op*4 + bm + pat) % 16), word);
          sendPkt(4'((op*4 + bm + pat) % 16), ad, hv);
          for (int i = 0; i < NS; i++)
            check((op == 0 || op > 8) ? "R6 no-op slot" : "R3/R4/R5 lane result",
                  hdrOut[i*FW +: FW], expHdr[i]);
          check("R8 drop flag", {31'd0, dropOut}, {31'd0, op[0] ^ pat[0]});
          check("R9 outValid after accept", {31'd0, outValid}, 32'd1);
        end
      end
    end

    // R7: swap slot 0 and 1, rotate slots 2..7; decrement wraps in slot 2 (R4)
    word = '0;
    word[0*UW +: UW] = mkUop(1, 1, 0, 0, 0);
    word[1*UW +: UW] = mkUop(1, 0, 0, 0, 0);
    for (int i = 2; i < NS; i++)
      word[i*UW +: UW] = mkUop(1, (i == NS-1) ? 2 : i + 1, 0, 0, 0);
    word[2*UW +: UW] = mkUop(8, 3, 0, 0, 0);
    writeInstr(4'd9, word);
    for (int i = 0; i < NS; i++) hv[i*FW +: FW] = 32'hA000_0000 + FW'(i);
    hv[3*FW +: FW] = 32'd0;
    sendPkt(4'd9, 32'd0, hv);
    check("R7 swap slot0", hdrOut[0*FW +: FW], 32'hA000_0001);
    check("R7 swap slot1", hdrOut[1*FW +: FW], 32'hA000_0000);
    check("R4 dec wrap slot2", hdrOut[2*FW +: FW], 32'hFFFF_FFFF);
    for (int i = 3; i < NS; i++)
      check("R7 rotate", hdrOut[i*FW +: FW], (i == NS-1) ? 32'hA000_0002 : hv[(i+1)*FW +: FW]);

    // R2: two entries hold different actions; actionIdx picks between them
    word = '0; wordB = '0;
    for (int i = 0; i < NS; i++) begin
      word[i*UW +: UW]  = mkUop(7, i, i, 2, 8'h11);
      wordB[i*UW +: UW] = mkUop(7, i, i, 2, 8'h22);
    end
    wordB[IW-1] = 1'b1;
    writeInstr(4'd3, word);
    writeInstr(4'd12, wordB);
    sendPkt(4'd12, 32'd0, '0);
    check("R2 entry 12", hdrOut[5*FW +: FW], 32'h22);
    check("R2 entry 12 drop", {31'd0, dropOut}, 32'd1);
    sendPkt(4'd3, 32'd0, '0);
    check("R2 entry 3", hdrOut[5*FW +: FW], 32'h11);
    check("R2 entry 3 drop", {31'd0, dropOut}, 32'd0);

    // R11: config write and lookup of the same entry in the same cycle
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'd3; cfgData = wordB;
    inValid = 1'b1; actionIdx = 4'd3; actionData = '0; hdrIn = '0;
    @(negedge clk);
    cfgWe = 1'b0; inValid = 1'b0;
    check("R11 same-cycle uses old word", hdrOut[0*FW +: FW], 32'h11);
    sendPkt(4'd3, 32'd0, '0);
    check("R11 later packet uses new word", hdrOut[0*FW +: FW], 32'h22);

    // R9: latency and drain
    @(negedge clk);
    check("R9 drained", {31'd0, outValid}, 32'd0);

    // R10: backpressure hold, then simultaneous release and accept
    outReady = 1'b0;
    for (int i = 0; i < NS; i++) hv[i*FW +: FW] = 32'h0000_1000 + FW'(i);
    writeInstr(4'd7, '0);
    sendPkt(4'd7, 32'd0, hv);
    held = hdrOut;
    check("R10 first packet out", hdrOut[4*FW +: FW], 32'h0000_1004);
    @(negedge clk);
    inValid = 1'b1; actionIdx = 4'd12; actionData = '0; hdrIn = hv;
    #1;
    check("R10 inReady low while stalled", {31'd0, inReady}, 32'd0);
    @(negedge clk);
    check("R10 output held", hdrOut[4*FW +: FW], held[4*FW +: FW]);
    check("R10 valid held", {31'd0, outValid}, 32'd1);
    outReady = 1'b1;
    #1;
    check("R10 inReady with outReady", {31'd0, inReady}, 32'd1);
    @(negedge clk);
    inValid = 1'b0;
    check("R10 second packet after release", hdrOut[4*FW +: FW], 32'h22);
    check("R10 second packet valid", {31'd0, outValid}, 32'd1);
    @(negedge clk);
    check("R9 drained after release", {31'd0, outValid}, 32'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule